// File: doc/BRIEF.md
# Soft Binary Tree Response Evaluator

This block computes the output of a soft binary decision tree for one sample. Each internal node carries a kernel response `f` between zero and one. A sample reaching a node with membership `m` goes to both children: the left child gets weight `m*f` and the right child gets `m*(1-f)`. Each leaf carries a label. The result is the membership-weighted average of the labels over every leaf the sample reaches.

The tree sits in a table of 31 slots in breadth-first order. The children of slot `i` are slots `2i+1` and `2i+2`. Each slot holds a leaf flag and a 16-bit value. For an internal node the value is the kernel response; for a leaf it is the label. All quantities are unsigned fixed point with 15 fraction bits, so `0x8000` means 1.0. A start pulse walks the table from the root, one slot per clock, and then runs a bit-serial divider. A done pulse marks the cycle in which the result becomes valid.

Top module: `fuzzy_tree_eval`

## Requirements
- R1: After reset, `busy` and `done` are low, `result` is 0, and every table slot is an internal node with value 0.
- R2: A cycle with `wr_en` high while `busy` is low stores `wr_leaf` and `wr_val` into slot `wr_idx`. A write in the same cycle as an accepted `start` is used by that evaluation.
- R3: The root (slot 0) has membership 1.0 (`0x8000`). A root marked as leaf with label L gives result L.
- R4: An internal node with membership m and response f gives its left child `(m*f)>>15` and its right child `(m*(0x8000-f))>>15`. A response above `0x8000` acts as `0x8000`.
- R5: Each reached leaf adds `(m*label)>>15` to a numerator and m to a denominator. The result is `floor(num*2^15/den)`, limited to `0xFFFF`, and 0 when den is 0.
- R6: Slots 15 to 30 are always leaves, whatever their flag. Slots not reached from the root through internal nodes have no effect on the result.
- R7: `start` while `busy` is high is ignored, and so is `wr_en` while `busy` is high.
- R8: An accepted `start` raises `busy` from the next cycle. `done` is a one-cycle pulse exactly 69 cycles after the edge that samples `start`, and `busy` falls in that same cycle.
- R9: `result` changes only in a cycle in which `done` is high, and it holds until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 5 | Slot written |
| wr_leaf | input | 1 | Leaf flag written |
| wr_val | input | 16 | Response or label written |
| start | input | 1 | Begin one evaluation |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| result | output | 16 | Normalized response |

## Verification
A table write and an accepted start can fall in the same cycle. The bench provokes this by driving both on one edge; the written slot is the root, turned into a leaf with a fresh label. The result must equal that new label, which shows the walk read the updated slot. The bench also sends a start and a write while the block is busy. It judges them by three things: no extra done pulse appears, the latency of the running evaluation is unchanged, and a later run gives the old value.

// File: rtl/fte_pkg.sv
package fte_pkg;
    localparam int W         = 16;
    localparam int FRAC      = 15;
    localparam int SLOTS_DEF = 31;
    localparam logic [W-1:0] ONE = 16'h8000;
    localparam int IDX_W_DEF = $clog2(SLOTS_DEF);
    localparam int ACC_W_DEF = W + IDX_W_DEF;

    typedef struct packed {
        logic         leaf;
        logic [W-1:0] val;
    } slot_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_DIV  = 2'd2
    } state_t;

    function automatic logic [W-1:0] qmul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [2*W-1:0] p;
        p = a * b;
        return p[FRAC+W-1:FRAC];
    endfunction

    function automatic logic [W-1:0] clamp_one(input logic [W-1:0] f);
        return (f > ONE) ? ONE : f;
    endfunction
endpackage

// File: rtl/fte_node_table.sv
module fte_node_table
    import fte_pkg::*;
#(
    parameter int SLOTS = SLOTS_DEF,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  slot_t            w_slot,
    input  logic [IDX_W-1:0] r_idx,
    output slot_t            r_slot
);
    slot_t cells [SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) cells[i] <= '0;
        end else if (we) begin
            cells[w_idx] <= w_slot;
        end
    end

    assign r_slot = cells[r_idx];
endmodule

// File: rtl/fte_walker.sv
module fte_walker
    import fte_pkg::*;
#(
    parameter int SLOTS = SLOTS_DEF,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int ACC_W = W + IDX_W,
    localparam int FIRST_LEAF = (SLOTS - 1) / 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    output logic [IDX_W-1:0] rd_idx,
    input  slot_t            rd_slot,
    output logic [ACC_W-1:0] sum_num,
    output logic [ACC_W-1:0] sum_den,
    output logic             fin
);
    logic [W-1:0]     mu [SLOTS];
    logic [SLOTS-1:0] reach;
    logic [IDX_W-1:0] idx;
    logic             active;

    logic [IDX_W-1:0] ch_l, ch_r;
    logic             as_leaf;
    logic [W-1:0]     f_eff, contrib, mu_l, mu_r;

    always_comb begin
        ch_l    = IDX_W'({idx, 1'b1});
        ch_r    = ch_l + 1'b1;
        as_leaf = rd_slot.leaf || (idx >= IDX_W'(FIRST_LEAF));
        f_eff   = clamp_one(rd_slot.val);
        contrib = qmul(mu[idx], rd_slot.val);
        mu_l    = qmul(mu[idx], f_eff);
        mu_r    = qmul(mu[idx], ONE - f_eff);
    end

    assign rd_idx = idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) mu[i] <= '0;
            reach   <= '0;
            idx     <= '0;
            active  <= 1'b0;
            sum_num <= '0;
            sum_den <= '0;
            fin     <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                idx      <= '0;
                active   <= 1'b1;
                sum_num  <= '0;
                sum_den  <= '0;
                reach    <= '0;
                reach[0] <= 1'b1;
                mu[0]    <= ONE;
            end else if (active) begin
                if (reach[idx]) begin
                    if (as_leaf) begin
                        sum_num <= sum_num + {{(ACC_W-W){1'b0}}, contrib};
                        sum_den <= sum_den + {{(ACC_W-W){1'b0}}, mu[idx]};
                    end else begin
                        mu[ch_l]    <= mu_l;
                        mu[ch_r]    <= mu_r;
                        reach[ch_l] <= 1'b1;
                        reach[ch_r] <= 1'b1;
                    end
                end
                if (idx == IDX_W'(SLOTS - 1)) begin
                    active <= 1'b0;
                    fin    <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/fte_divider.sv
module fte_divider #(
    parameter int N_W = 36,
    parameter int D_W = 21,
    localparam int CNT_W = $clog2(N_W + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [N_W-1:0] dividend,
    input  logic [D_W-1:0] divisor,
    output logic [N_W-1:0] quotient,
    output logic           fin
);
    logic [D_W-1:0]   rem, dvs;
    logic [CNT_W-1:0] cnt;
    logic [D_W:0]     rem_sh;
    logic             ge;

    always_comb begin
        rem_sh = {rem, quotient[N_W-1]};
        ge     = rem_sh >= {1'b0, dvs};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            quotient <= '0;
            rem      <= '0;
            dvs      <= '0;
            cnt      <= '0;
            fin      <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (load) begin
                quotient <= dividend;
                dvs      <= divisor;
                rem      <= '0;
                cnt      <= CNT_W'(N_W);
            end else if (cnt != '0) begin
                rem      <= ge ? D_W'(rem_sh - {1'b0, dvs}) : rem_sh[D_W-1:0];
                quotient <= {quotient[N_W-2:0], ge};
                cnt      <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) fin <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fuzzy_tree_eval.sv
module fuzzy_tree_eval
    import fte_pkg::*;
#(
    parameter int SLOTS = SLOTS_DEF,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int ACC_W = W + IDX_W,
    localparam int QUO_W = ACC_W + FRAC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_leaf,
    input  logic [W-1:0]     wr_val,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic [W-1:0]     result
);
    state_t           state;
    logic             go, tbl_we, walk_fin, div_fin;
    logic [IDX_W-1:0] rd_idx;
    slot_t            rd_slot;
    logic [ACC_W-1:0] sum_num, sum_den;
    logic [QUO_W-1:0] quo;
    logic [W-1:0]     res_nx;

    assign go     = start && (state == ST_IDLE);
    assign tbl_we = wr_en && (state == ST_IDLE);
    assign busy   = (state != ST_IDLE);

    fte_node_table #(.SLOTS(SLOTS)) u_tbl (
        .clk(clk), .rst(rst), .we(tbl_we), .w_idx(wr_idx),
        .w_slot('{leaf: wr_leaf, val: wr_val}),
        .r_idx(rd_idx), .r_slot(rd_slot)
    );

    fte_walker #(.SLOTS(SLOTS)) u_walk (
        .clk(clk), .rst(rst), .go(go), .rd_idx(rd_idx), .rd_slot(rd_slot),
        .sum_num(sum_num), .sum_den(sum_den), .fin(walk_fin)
    );

    fte_divider #(.N_W(QUO_W), .D_W(ACC_W)) u_div (
        .clk(clk), .rst(rst), .load(walk_fin),
        .dividend({sum_num, {FRAC{1'b0}}}), .divisor(sum_den),
        .quotient(quo), .fin(div_fin)
    );

    always_comb begin
        if (sum_den == '0)                        res_nx = '0;
        else if (quo > QUO_W'({W{1'b1}}))         res_nx = {W{1'b1}};
        else                                      res_nx = quo[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (go) state <= ST_WALK;
                ST_WALK: if (walk_fin) state <= ST_DIV;
                ST_DIV: if (div_fin) begin
                    state  <= ST_IDLE;
                    done   <= 1'b1;
                    result <= res_nx;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fte_checker.sv
module fte_checker
    import fte_pkg::*;
#(
    parameter int ACC_W = ACC_W_DEF
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [W-1:0]     result,
    input logic [ACC_W-1:0] sum_den
);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    assert_den_bound_R4: assert property (@(posedge clk) disable iff (rst)
        sum_den <= ACC_W'(ONE));
endmodule

bind fuzzy_tree_eval fte_checker u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .done(done), .result(result), .sum_den(sum_den)
);

// File: tb/sim_fuzzy_tree_eval.sv
`timescale 1ns/100ps
module sim_fuzzy_tree_eval;
    localparam int N = 31;
    localparam int LAT = 69;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_leaf = 1'b0, start = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [15:0] wr_val = '0;
    logic        busy, done;
    logic [15:0] result;

    fuzzy_tree_eval u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_leaf(wr_leaf),
        .wr_val(wr_val), .start(start), .busy(busy), .done(done), .result(result)
    );

    always #2.5 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    logic        sh_leaf [N];
    logic [15:0] sh_val  [N];
    logic [15:0] exp_q [$];
    string       tag_q [$];
    int          t0_q  [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model();
        longint mu [N];
        bit     rch [N];
        longint num = 0, den = 0, q, f;
        for (int i = 0; i < N; i++) begin mu[i] = 0; rch[i] = 0; end
        mu[0] = 32768; rch[0] = 1;
        for (int i = 0; i < N; i++) begin
            if (rch[i]) begin
                if (sh_leaf[i] || i >= 15) begin
                    num += (mu[i] * sh_val[i]) >> 15;
                    den += mu[i];
                end else begin
                    f = (sh_val[i] > 16'h8000) ? 32768 : sh_val[i];
                    mu[2*i+1] = (mu[i] * f) >> 15;
                    mu[2*i+2] = (mu[i] * (32768 - f)) >> 15;
                    rch[2*i+1] = 1; rch[2*i+2] = 1;
                end
            end
        end
        if (den == 0) return 16'h0;
        q = (num << 15) / den;
        return (q > 65535) ? 16'hFFFF : 16'(q);
    endfunction

    task automatic wr(input int idx, input bit leaf, input int val, input bit taken);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'(idx); wr_leaf = leaf; wr_val = 16'(val);
        @(negedge clk);
        wr_en = 1'b0;
        if (taken) begin sh_leaf[idx] = leaf; sh_val[idx] = 16'(val); end
    endtask

    task automatic run(input logic [15:0] exp, input string tag);
        @(negedge clk);
        start = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(posedge clk); #1;
        t0_q.push_back(cyc);
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R8 busy after start", busy, 1);
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected done", result, 0);
            end else begin
                logic [15:0] e;
                string tg;
                int t0;
                e = exp_q.pop_front(); tg = tag_q.pop_front(); t0 = t0_q.pop_front();
                chk(result === e, tg, result, e);
                chk(cyc - t0 == LAT, "R8 latency", cyc - t0, LAT);
                chk(busy === 1'b0, "R8 busy low at done", busy, 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] held, prev;
        for (int i = 0; i < N; i++) begin sh_leaf[i] = 0; sh_val[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0, "R1 busy", busy, 0);
        chk(done === 1'b0, "R1 done", done, 0);
        chk(result === 16'h0, "R1 result", result, 0);

        // R1: reset table is all internal zero-response nodes: root mu ends in slot 30 chain
        run(model(), "R1 reset table result");
        wait_idle();

        // R3: root as leaf
        wr(0, 1, 16'h6000, 1);
        run(16'h6000, "R3 root leaf");
        wait_idle();

        // R4: one split, f=0.75, labels 1.0 and 0
        wr(0, 0, 16'h6000, 1);
        wr(1, 1, 16'h8000, 1);
        wr(2, 1, 16'h0000, 1);
        run(16'h6000, "R4 single split");
        wait_idle();

        // R6: unreached slots carry garbage, no effect
        for (int i = 3; i < 7; i++) wr(i, i[0], 16'hFFFF - i, 1);
        run(16'h6000, "R6 unreached slots ignored");
        wait_idle();

        // R4: response above one clamps to one
        wr(0, 0, 16'hFFFF, 1);
        wr(1, 1, 16'h1000, 1);
        wr(2, 1, 16'h7000, 1);
        run(16'h1000, "R4 clamp above one");
        wait_idle();

        // R5: seventeen-node tree, slots 15,16 flagged internal but fixed leaves (R6)
        for (int i = 0; i < 8; i++) wr(i, 0, 16'h0C00 * (i + 1) + 37 * i, 1);
        for (int i = 8; i < 15; i++) wr(i, 1, 16'h1700 * (i - 7) + 11, 1);
        wr(15, 0, 16'hF123, 1);
        wr(16, 0, 16'h0456, 1);
        run(model(), "R5 seventeen-node tree");
        wait_idle();

        // R6: deep left spine reaching fixed leaf slot 15
        wr(0, 0, 16'h7000, 1);
        wr(1, 0, 16'h5000, 1);
        wr(3, 0, 16'h3000, 1);
        wr(7, 0, 16'h6800, 1);
        run(model(), "R6 deep spine");
        wait_idle();

        // R5: large labels across leaves
        wr(0, 0, 16'h4000, 1);
        wr(1, 1, 16'hFFFF, 1);
        wr(2, 1, 16'hFFFF, 1);
        run(model(), "R5 max labels");
        wait_idle();

        // R9: result held between done pulses
        held = result;
        repeat (10) @(negedge clk);
        chk(result === held, "R9 result held", result, held);

        // R7: start and write while busy are ignored
        prev = model();
        run(prev, "R7 run with busy stimulus");
        repeat (10) @(negedge clk);
        start = 1'b1; wr_en = 1'b1; wr_idx = 5'd0; wr_leaf = 1'b1; wr_val = 16'h1111;
        @(negedge clk);
        start = 1'b0; wr_en = 1'b0;
        wait_idle();
        run(prev, "R7 write while busy dropped");
        wait_idle();

        // R2: write and start in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'd0; wr_leaf = 1'b1; wr_val = 16'h3000; start = 1'b1;
        sh_leaf[0] = 1'b1; sh_val[0] = 16'h3000;
        exp_q.push_back(16'h3000); tag_q.push_back("R2 same-cycle write and start");
        @(posedge clk); #1;
        t0_q.push_back(cyc);
        @(negedge clk);
        wr_en = 1'b0; start = 1'b0;
        wait_idle();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule